// File: doc/BRIEF.md
# Integer Decode and Execute Stage

This block decodes one 32-bit instruction word of a three-operand load/store RISC instruction set. It also performs the integer part of that instruction on two operand values that the register file has already read. The word and both operands are presented with a valid strobe. One clock later the stage gives out the destination register index, a write enable, the result, the load/store effective address, and two flags: one for an illegal instruction and one for a halt request.

Optional execution units are enabled through four feature inputs: barrel shifter, multiplier, divider and sign extender. When a unit is absent, the instructions that need it raise the illegal flag and write nothing. Branches, control registers, the multiply and divide datapaths, memory access and the register file are all handled elsewhere. For those opcodes this stage makes no write and raises no flag.

Top module: `rdx_exec_stage`

## Requirements
- R1: The opcode is bits 31:26 and bit 31 selects the format: set means register-register with destination bits 15:11 and second operand `opb`; clear means register-immediate with destination bits 20:16 and the immediate as second operand. Add is 0x0D/0x2D and subtract is 0x32.
- R2: Add-immediate (0x0D), signed compares-immediate (0x19, 0x1A, 0x1B, 0x1F) and the address output `ls_addr` use the 16-bit immediate (bits 15:0) sign-extended; `ls_addr` = `opa` + that value for every accepted word.
- R3: AND (0x08/0x28), OR (0x0E/0x2E), XOR (0x06/0x26), NOR (0x01/0x21), XNOR (0x09/0x29) and the unsigned compares (0x1C greater-or-equal, 0x1D greater) zero-extend the immediate.
- R4: AND-high (0x18) and OR-high (0x1E) shift the immediate into bits 31:16 with zeros below before the operation.
- R5: Compares write exactly 1 or 0: equal 0x19/0x39, greater 0x1A/0x3A, greater-or-equal 0x1B/0x3B, unsigned greater-or-equal 0x1C/0x3C, unsigned greater 0x1D/0x3D, not-equal 0x1F/0x3F.
- R6: The shift amount is the low 5 bits of the second operand (imm bits 4:0 in immediate form). Left shift is 0x0F/0x2F, arithmetic right is 0x05/0x25, logical right is 0x00/0x20.
- R7: With `feat_shift` low, a right shift by exactly 1 still executes; any other right amount, and every left shift, raises `illegal`.
- R8: Multiply (0x02/0x22) needs `feat_mul`; divide (0x23) and modulo (0x31) need `feat_div`; byte sign-extend (0x2C) and half sign-extend (0x37) need `feat_sext`. A missing unit raises `illegal`. Sign-extend writes `opa` bits 7:0 or 15:0 sign-extended. Multiply, divide and modulo never write here.
- R9: A register-form AND (0x28) with bits 25:11 all zero raises `halt` and performs no write and no illegal flag.
- R10: The user opcode 0x33 and the unassigned opcodes 0x27, 0x2A and 0x35 raise `illegal`.
- R11: A write whose destination is register 0 is suppressed.
- R12: Outputs are registered: they reflect the word accepted at the previous rising edge with `in_valid` high. With no accepted word, and after synchronous active-low reset, `out_valid`, `wr_en`, `illegal`, `halt`, `result` and `ls_addr` are all zero.
- R13: An illegal instruction never asserts `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are presented |
| insn | input | 32 | Instruction word |
| opa | input | 32 | Value of the register named by bits 25:21 |
| opb | input | 32 | Value of the register named by bits 20:16 |
| feat_shift | input | 1 | Barrel shifter present |
| feat_mul | input | 1 | Multiplier present |
| feat_div | input | 1 | Divider present |
| feat_sext | input | 1 | Sign extender present |
| out_valid | output | 1 | Outputs belong to an accepted word |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write the result to `dst_idx` |
| result | output | 32 | Integer result |
| ls_addr | output | 32 | `opa` plus the sign-extended immediate |
| illegal | output | 1 | Illegal instruction |
| halt | output | 1 | Halt request |

## Verification
Two things can act on the same word. Shift legality, which depends on the operand value when the shifter is absent, can coincide with the suppression of writes to register 0. Directed words cover each case: a right shift by 1 and by 2 to a nonzero destination, and an illegal shift aimed at register 0. For each one, `illegal` and `wr_en` are judged together. Halt is also provoked next to a register-form AND with one nonzero field, so that only the all-zero pattern stops the stage. A reference model in the bench then checks many random operand and field combinations of the arithmetic, logic, compare and shift opcodes.

// File: rtl/rdx_pkg.sv
`timescale 1ns/1ps
// Shared types for the decode/execute stage.
// Assumes a 32-bit instruction word with a 6-bit opcode in bits 31:26.
package rdx_pkg;
    localparam int unsigned INSN_W = 32;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned SHAMT_W = 5;

    localparam logic [OPC_W-1:0] OPC_AND_REG = 6'h28;

    typedef enum logic [4:0] {
        OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_XNOR,
        OP_SL, OP_SR, OP_SRU, OP_CEQ, OP_CNE, OP_CGT, OP_CGE, OP_CGTU,
        OP_CGEU, OP_SXB, OP_SXH
    } alu_op_e;

    typedef enum logic [1:0] { IMM_SEXT, IMM_ZEXT, IMM_HIGH } imm_e;

    typedef enum logic [2:0] {
        UNIT_NONE, UNIT_SHIFT, UNIT_MUL, UNIT_DIV, UNIT_SEXT
    } unit_e;

    typedef struct packed {
        alu_op_e op;
        imm_e    imm;
        logic    writes;
        logic    bad;
        logic    shl;
        logic    shr;
        unit_e   unit;
    } ctrl_t;
endpackage

// File: rtl/rdx_decode.sv
`timescale 1ns/1ps
// Opcode classifier: maps the 6-bit opcode to an ALU operation,
// immediate extension kind, write intent and required optional unit.
// Assumes bit 5 of the opcode is the format bit (1 = register form).
module rdx_decode
    import rdx_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output ctrl_t            ctrl
);
    // Classify the opcode.
    always_comb begin
        ctrl        = '0;
        ctrl.op     = OP_NONE;
        ctrl.imm    = IMM_SEXT;
        ctrl.unit   = UNIT_NONE;
        case (opc)
            6'h00, 6'h20: begin ctrl.op = OP_SRU; ctrl.writes = 1'b1; ctrl.shr = 1'b1; ctrl.unit = UNIT_SHIFT; end
            6'h05, 6'h25: begin ctrl.op = OP_SR;  ctrl.writes = 1'b1; ctrl.shr = 1'b1; ctrl.unit = UNIT_SHIFT; end
            6'h0F, 6'h2F: begin ctrl.op = OP_SL;  ctrl.writes = 1'b1; ctrl.shl = 1'b1; ctrl.unit = UNIT_SHIFT; end
            6'h01, 6'h21: begin ctrl.op = OP_NOR;  ctrl.imm = IMM_ZEXT; ctrl.writes = 1'b1; end
            6'h06, 6'h26: begin ctrl.op = OP_XOR;  ctrl.imm = IMM_ZEXT; ctrl.writes = 1'b1; end
            6'h08, 6'h28: begin ctrl.op = OP_AND;  ctrl.imm = IMM_ZEXT; ctrl.writes = 1'b1; end
            6'h09, 6'h29: begin ctrl.op = OP_XNOR; ctrl.imm = IMM_ZEXT; ctrl.writes = 1'b1; end
            6'h0E, 6'h2E: begin ctrl.op = OP_OR;   ctrl.imm = IMM_ZEXT; ctrl.writes = 1'b1; end
            6'h0D, 6'h2D: begin ctrl.op = OP_ADD;  ctrl.writes = 1'b1; end
            6'h32:        begin ctrl.op = OP_SUB;  ctrl.writes = 1'b1; end
            6'h18:        begin ctrl.op = OP_AND;  ctrl.imm = IMM_HIGH; ctrl.writes = 1'b1; end
            6'h1E:        begin ctrl.op = OP_OR;   ctrl.imm = IMM_HIGH; ctrl.writes = 1'b1; end
            6'h19, 6'h39: begin ctrl.op = OP_CEQ;  ctrl.writes = 1'b1; end
            6'h1A, 6'h3A: begin ctrl.op = OP_CGT;  ctrl.writes = 1'b1; end
            6'h1B, 6'h3B: begin ctrl.op = OP_CGE;  ctrl.writes = 1'b1; end
            6'h1C, 6'h3C: begin ctrl.op = OP_CGEU; ctrl.imm = IMM_ZEXT; ctrl.writes = 1'b1; end
            6'h1D, 6'h3D: begin ctrl.op = OP_CGTU; ctrl.imm = IMM_ZEXT; ctrl.writes = 1'b1; end
            6'h1F, 6'h3F: begin ctrl.op = OP_CNE;  ctrl.writes = 1'b1; end
            6'h2C:        begin ctrl.op = OP_SXB;  ctrl.writes = 1'b1; ctrl.unit = UNIT_SEXT; end
            6'h37:        begin ctrl.op = OP_SXH;  ctrl.writes = 1'b1; ctrl.unit = UNIT_SEXT; end
            6'h02, 6'h22: ctrl.unit = UNIT_MUL;
            6'h23, 6'h31: ctrl.unit = UNIT_DIV;
            6'h27, 6'h2A, 6'h33, 6'h35: ctrl.bad = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rdx_alu.sv
`timescale 1ns/1ps
// Integer ALU: logic, add/subtract, compares, shifts and sign-extension.
// Assumes the shift amount is already in the low SHAMT_W bits of b.
module rdx_alu
    import rdx_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y
);
    logic [SHAMT_W-1:0] amt;
    assign amt = b[SHAMT_W-1:0];

    // Select the operation result.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_XNOR: y = ~(a ^ b);
            OP_SL:   y = a << amt;
            OP_SR:   y = $signed(a) >>> amt;
            OP_SRU:  y = a >> amt;
            OP_CEQ:  y = XLEN'(a == b);
            OP_CNE:  y = XLEN'(a != b);
            OP_CGT:  y = XLEN'($signed(a) > $signed(b));
            OP_CGE:  y = XLEN'($signed(a) >= $signed(b));
            OP_CGTU: y = XLEN'(a > b);
            OP_CGEU: y = XLEN'(a >= b);
            OP_SXB:  y = XLEN'($signed(a[7:0]));
            OP_SXH:  y = XLEN'($signed(a[15:0]));
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/rdx_exec_stage.sv
`timescale 1ns/1ps
// Decode/execute stage top: field extraction, immediate extension,
// optional-unit gating, halt detection and the output register.
// Assumes XLEN >= 32; results appear one cycle after in_valid.
module rdx_exec_stage
    import rdx_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic              feat_shift,
    input  logic              feat_mul,
    input  logic              feat_div,
    input  logic              feat_sext,
    output logic              out_valid,
    output logic [RIDX_W-1:0] dst_idx,
    output logic              wr_en,
    output logic [XLEN-1:0]   result,
    output logic [XLEN-1:0]   ls_addr,
    output logic              illegal,
    output logic              halt
);
    logic [OPC_W-1:0]  opc;
    logic              reg_form;
    logic [RIDX_W-1:0] dst_c;
    logic [IMM_W-1:0]  imm16;
    logic [XLEN-1:0]   imm_ext, opnd_b, alu_y, addr_c;
    ctrl_t             ctrl;
    logic              gate_bad, illegal_c, halt_c, wr_c, cmp_c;

    assign opc      = insn[INSN_W-1 -: OPC_W];
    assign reg_form = insn[INSN_W-1];
    assign imm16    = insn[IMM_W-1:0];
    assign dst_c    = reg_form ? insn[15:11] : insn[20:16];

    rdx_decode u_dec (.opc(opc), .ctrl(ctrl));

    // Extend the immediate according to the opcode class.
    always_comb begin
        case (ctrl.imm)
            IMM_ZEXT: imm_ext = XLEN'(imm16);
            IMM_HIGH: imm_ext = XLEN'({imm16, {IMM_W{1'b0}}});
            default:  imm_ext = XLEN'($signed(imm16));
        endcase
    end

    assign opnd_b = reg_form ? opb : imm_ext;
    assign addr_c = opa + XLEN'($signed(imm16));

    rdx_alu #(.XLEN(XLEN)) u_alu (.op(ctrl.op), .a(opa), .b(opnd_b), .y(alu_y));

    // Refuse instructions whose optional unit is configured out.
    always_comb begin
        case (ctrl.unit)
            UNIT_SHIFT: gate_bad = !feat_shift &&
                        (ctrl.shl || (opnd_b[SHAMT_W-1:0] != SHAMT_W'(1)));
            UNIT_MUL:   gate_bad = !feat_mul;
            UNIT_DIV:   gate_bad = !feat_div;
            UNIT_SEXT:  gate_bad = !feat_sext;
            default:    gate_bad = 1'b0;
        endcase
    end

    assign halt_c    = (opc == OPC_AND_REG) && (insn[25:11] == '0);
    assign illegal_c = ctrl.bad || gate_bad;
    assign wr_c      = ctrl.writes && !illegal_c && !halt_c && (dst_c != '0);
    assign cmp_c     = ctrl.op inside {OP_CEQ, OP_CNE, OP_CGT, OP_CGE, OP_CGTU, OP_CGEU};

    // Register the stage outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            dst_idx   <= '0;
            wr_en     <= 1'b0;
            result    <= '0;
            ls_addr   <= '0;
            illegal   <= 1'b0;
            halt      <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            dst_idx   <= dst_c;
            wr_en     <= wr_c;
            result    <= alu_y;
            ls_addr   <= addr_c;
            illegal   <= illegal_c;
            halt      <= halt_c;
        end
    end

    assert_r0_never_written_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dst_idx != '0));
    assert_illegal_blocks_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);
    assert_halt_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!wr_en && !illegal));
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(wr_en || illegal || halt));
    assert_accept_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_compare_boolean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmp_c) |=> (result[XLEN-1:1] == '0));
endmodule

// File: tb/rdx_exec_stage_bench.sv
`timescale 1ns/1ps
module rdx_exec_stage_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0, opa = '0, opb = '0;
    logic        feat_shift = 1'b1, feat_mul = 1'b1, feat_div = 1'b1, feat_sext = 1'b1;
    logic        out_valid, wr_en, illegal, halt;
    logic [4:0]  dst_idx;
    logic [31:0] result, ls_addr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rdx_exec_stage u_rdx_exec_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .opa(opa), .opb(opb), .feat_shift(feat_shift), .feat_mul(feat_mul),
        .feat_div(feat_div), .feat_sext(feat_sext), .out_valid(out_valid),
        .dst_idx(dst_idx), .wr_en(wr_en), .result(result), .ls_addr(ls_addr),
        .illegal(illegal), .halt(halt));

    function automatic logic [31:0] ri(logic [5:0] op, logic [4:0] rs, logic [4:0] rd, logic [15:0] imm);
        return {op, rs, rd, imm};
    endfunction
    function automatic logic [31:0] rr(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
        return {op, rs, rt, rd, 11'b0};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        insn = w; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Check a writing result: value, destination, no flags.
    task automatic expect_wr(string tag, logic [4:0] rd, logic [31:0] v);
        chk({tag, " result"}, result, v);
        chk({tag, " dst"}, 32'(dst_idx), 32'(rd));
        chk({tag, " wr/ill/halt"}, {29'b0, wr_en, illegal, halt}, 32'b100);
    endtask

    task automatic t_reset;
        chk("R12 reset outputs", {out_valid, wr_en, illegal, halt}, '0);
        chk("R12 reset result", result, '0);
    endtask

    task automatic t_arith;
        issue(ri(6'h0D, 5'd1, 5'd3, 16'hFFFF), 32'd10, 32'd0);
        expect_wr("R1 R2 addi", 5'd3, 32'd9);
        issue(rr(6'h2D, 5'd1, 5'd2, 5'd7), 32'd5, 32'd7);
        expect_wr("R1 add reg", 5'd7, 32'd12);
        issue(rr(6'h32, 5'd1, 5'd2, 5'd4), 32'd5, 32'd7);
        expect_wr("R1 sub", 5'd4, 32'hFFFF_FFFE);
    endtask

    task automatic t_logic;
        issue(ri(6'h08, 5'd1, 5'd2, 16'h8001), 32'hFFFF_FFFF, 32'd0);
        expect_wr("R3 andi", 5'd2, 32'h0000_8001);
        issue(ri(6'h06, 5'd1, 5'd2, 16'hFFFF), 32'd0, 32'd0);
        expect_wr("R3 xori", 5'd2, 32'h0000_FFFF);
        issue(rr(6'h21, 5'd1, 5'd2, 5'd5), 32'h0F0F_0000, 32'h0000_00F0);
        expect_wr("R3 nor", 5'd5, 32'hF0F0_FF0F);
        issue(ri(6'h09, 5'd1, 5'd2, 16'h5678), 32'h1234_5678, 32'd0);
        expect_wr("R3 xnori", 5'd2, 32'hEDCB_FFFF);
    endtask

    task automatic t_high;
        issue(ri(6'h18, 5'd1, 5'd2, 16'hABCD), 32'hFFFF_FFFF, 32'd0);
        expect_wr("R4 and-high", 5'd2, 32'hABCD_0000);
        issue(ri(6'h1E, 5'd1, 5'd2, 16'h8000), 32'h0000_1234, 32'd0);
        expect_wr("R4 or-high", 5'd2, 32'h8000_1234);
    endtask

    task automatic t_compare;
        issue(ri(6'h1A, 5'd1, 5'd2, 16'hFFFF), 32'd0, 32'd0);
        expect_wr("R5 R2 cmpgt imm signed", 5'd2, 32'd1);
        issue(ri(6'h1D, 5'd1, 5'd2, 16'hFFFF), 32'd0, 32'd0);
        expect_wr("R5 R3 cmpgtu imm zext", 5'd2, 32'd0);
        issue(rr(6'h3C, 5'd1, 5'd2, 5'd6), 32'hFFFF_FFFF, 32'd1);
        expect_wr("R5 cmpgeu reg", 5'd6, 32'd1);
        issue(rr(6'h3B, 5'd1, 5'd2, 5'd6), 32'hFFFF_FFFF, 32'd1);
        expect_wr("R5 cmpge reg", 5'd6, 32'd0);
        issue(ri(6'h19, 5'd1, 5'd2, 16'd5), 32'd5, 32'd0);
        expect_wr("R5 cmpeq imm", 5'd2, 32'd1);
        issue(rr(6'h3F, 5'd1, 5'd2, 5'd6), 32'd9, 32'd9);
        expect_wr("R5 cmpne reg", 5'd6, 32'd0);
    endtask

    task automatic t_shift;
        feat_shift = 1'b1;
        issue(rr(6'h25, 5'd1, 5'd2, 5'd8), 32'h8000_0000, 32'h0000_0024);
        expect_wr("R6 sr reg low5", 5'd8, 32'hF800_0000);
        issue(ri(6'h00, 5'd1, 5'd2, 16'd4), 32'h8000_0000, 32'd0);
        expect_wr("R6 sru imm", 5'd2, 32'h0800_0000);
        issue(ri(6'h0F, 5'd1, 5'd2, 16'd3), 32'd1, 32'd0);
        expect_wr("R6 sl imm", 5'd2, 32'd8);
    endtask

    task automatic t_noshift;
        feat_shift = 1'b0;
        issue(ri(6'h05, 5'd1, 5'd2, 16'd1), 32'h8000_0000, 32'd0);
        expect_wr("R7 sr by 1", 5'd2, 32'hC000_0000);
        issue(rr(6'h20, 5'd1, 5'd2, 5'd9), 32'h8000_0000, 32'h0000_0021);
        expect_wr("R7 sru reg by 1", 5'd9, 32'h4000_0000);
        issue(ri(6'h05, 5'd1, 5'd2, 16'd2), 32'h8000_0000, 32'd0);
        chk("R7 R13 sr by 2 illegal", {wr_en, illegal}, 2'b01);
        issue(ri(6'h0F, 5'd1, 5'd2, 16'd1), 32'd1, 32'd0);
        chk("R7 sl illegal", {wr_en, illegal}, 2'b01);
        issue(ri(6'h05, 5'd1, 5'd0, 16'd2), 32'd4, 32'd0);
        chk("R7 R11 illegal shift to r0", {wr_en, illegal}, 2'b01);
        feat_shift = 1'b1;
    endtask

    task automatic t_units;
        feat_mul = 1'b0;
        issue(rr(6'h22, 5'd1, 5'd2, 5'd3), 32'd3, 32'd4);
        chk("R8 mul absent", {wr_en, illegal}, 2'b01);
        feat_mul = 1'b1;
        issue(rr(6'h22, 5'd1, 5'd2, 5'd3), 32'd3, 32'd4);
        chk("R8 mul present", {wr_en, illegal}, 2'b00);
        feat_div = 1'b0;
        issue(rr(6'h23, 5'd1, 5'd2, 5'd3), 32'd3, 32'd4);
        chk("R8 div absent", {wr_en, illegal}, 2'b01);
        issue(rr(6'h31, 5'd1, 5'd2, 5'd3), 32'd3, 32'd4);
        chk("R8 mod absent", {wr_en, illegal}, 2'b01);
        feat_div = 1'b1;
        issue(rr(6'h2C, 5'd1, 5'd0, 5'd3), 32'h0000_0080, 32'd0);
        expect_wr("R8 sext byte", 5'd3, 32'hFFFF_FF80);
        issue(rr(6'h37, 5'd1, 5'd0, 5'd3), 32'h0001_7FFF, 32'd0);
        expect_wr("R8 sext half", 5'd3, 32'h0000_7FFF);
        feat_sext = 1'b0;
        issue(rr(6'h2C, 5'd1, 5'd0, 5'd3), 32'h0000_0080, 32'd0);
        chk("R8 sext absent", {wr_en, illegal}, 2'b01);
        feat_sext = 1'b1;
    endtask

    task automatic t_halt;
        issue(32'hA000_0000, 32'd0, 32'd0);
        chk("R9 halt", {wr_en, illegal, halt}, 3'b001);
        issue(rr(6'h28, 5'd0, 5'd0, 5'd1), 32'hF0, 32'h3C);
        expect_wr("R9 and not halt", 5'd1, 32'h30);
    endtask

    task automatic t_illegal;
        logic [5:0] bad [4] = '{6'h33, 6'h27, 6'h2A, 6'h35};
        foreach (bad[i]) begin
            issue(rr(bad[i], 5'd1, 5'd2, 5'd3), 32'd1, 32'd1);
            chk($sformatf("R10 opcode %h", bad[i]), {wr_en, illegal, halt}, 3'b010);
        end
    endtask

    task automatic t_r0_and_addr;
        issue(ri(6'h0D, 5'd1, 5'd0, 16'd7), 32'd1, 32'd0);
        chk("R11 write to r0", {out_valid, wr_en, illegal}, 3'b100);
        issue(ri(6'h0A, 5'd1, 5'd2, 16'hFFFC), 32'h0000_1000, 32'd0);
        chk("R2 load address", ls_addr, 32'h0000_0FFC);
        chk("R2 load no write", 32'(wr_en), 32'd0);
        @(negedge clk);
        chk("R12 idle after word", {out_valid, wr_en, illegal, halt}, '0);
    endtask

    // Independent model of the writing integer opcodes (all units present).
    function automatic logic [32:0] model(logic [31:0] w, logic [31:0] a, logic [31:0] b);
        logic [5:0]  op = w[31:26];
        logic        rf = w[31];
        logic [4:0]  rd = rf ? w[15:11] : w[20:16];
        logic [31:0] bs = rf ? b : {{16{w[15]}}, w[15:0]};
        logic [31:0] bz = rf ? b : {16'h0, w[15:0]};
        logic [31:0] v = '0;
        logic        wr = 1'b1;
        if (op == 6'h32) v = a - b;
        else if (op == 6'h18) v = a & {w[15:0], 16'h0};
        else if (op == 6'h1E) v = a | {w[15:0], 16'h0};
        else case (op[4:0])
            5'h0D: v = a + bs;
            5'h08: begin v = a & bz; if (rf && w[25:11] == '0) wr = 1'b0; end
            5'h0E: v = a | bz;
            5'h06: v = a ^ bz;
            5'h01: v = ~(a | bz);
            5'h09: v = ~(a ^ bz);
            5'h19: v = {31'b0, a == bs};
            5'h1A: v = {31'b0, $signed(a) > $signed(bs)};
            5'h1B: v = {31'b0, $signed(a) >= $signed(bs)};
            5'h1C: v = {31'b0, a >= bz};
            5'h1D: v = {31'b0, a > bz};
            5'h1F: v = {31'b0, a != bs};
            5'h00: v = a >> bz[4:0];
            5'h05: v = $signed(a) >>> bz[4:0];
            5'h0F: v = a << bz[4:0];
            default: wr = 1'b0;
        endcase
        if (rd == 5'd0) wr = 1'b0;
        return {wr, v};
    endfunction

    task automatic t_random;
        logic [5:0] ops [31] = '{6'h0D, 6'h2D, 6'h32, 6'h08, 6'h28, 6'h0E, 6'h2E,
            6'h06, 6'h26, 6'h01, 6'h21, 6'h09, 6'h29, 6'h19, 6'h1A, 6'h1B, 6'h1C,
            6'h1D, 6'h1F, 6'h39, 6'h3A, 6'h3B, 6'h3C, 6'h3D, 6'h3F, 6'h18, 6'h1E,
            6'h00, 6'h20, 6'h05, 6'h2F};
        for (int n = 0; n < 300; n++) begin
            logic [31:0] w = {ops[$urandom_range(30)], 26'($urandom)};
            logic [31:0] a = $urandom;
            logic [31:0] b = (n % 3 == 0) ? a : $urandom;
            logic [32:0] m = model(w, a, b);
            issue(w, a, b);
            chk($sformatf("R1 R6 model wr %h", w), 32'(wr_en), 32'(m[32]));
            if (m[32]) chk($sformatf("R2 R3 R5 model result %h", w), result, m[31:0]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_arith;
        t_logic;
        t_high;
        t_compare;
        t_shift;
        t_noshift;
        t_units;
        t_halt;
        t_illegal;
        t_r0_and_addr;
        t_random;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule